// File: doc/BRIEF.md
# Guard-Round-Sticky Rounding Unit

This combinational stage sits after the normalizer of a floating-point datapath. It receives a normalized mantissa whose two lowest bits are extra precision (guard above round), a separate sticky bit that summarizes everything shifted out earlier, the sign of the value, and a 2-bit rounding-mode code. It drops the two extra bits and adds one unit in the last place when the selected mode asks for it.

Alongside the rounded mantissa it reports whether any precision was lost (inexact), whether the increment was applied (rounded up), and the carry that leaves the top of the mantissa when an all-ones value is incremented. The stage never renormalizes. When the carry is set, the mantissa reads zero and the value is 2.0, and the caller must adjust the exponent.

Top module: `grs_round_unit`

## Requirements
- R1: `mant_o` equals `mant_i` shifted right by two, plus one when an increment is applied. Bit 1 of `mant_i` is the guard bit and bit 0 is the round bit.
- R2: When guard, round and `sticky_i` are all zero, `inexact_o`, `rounded_up_o` and `carry_o` are 0 and `mant_o` is `mant_i >> 2`, for every mode.
- R3: `inexact_o` is 1 exactly when guard, round or `sticky_i` is 1.
- R4: With mode 0 (nearest, ties to even), the increment applies exactly when guard is 1 and at least one of round, `sticky_i` or `mant_i[2]` is 1.
- R5: With mode 1 (toward zero), no increment is ever applied.
- R6: With mode 2 (toward plus infinity), the increment applies exactly when the result is inexact and `sign_i` is 0.
- R7: With mode 3 (toward minus infinity), the increment applies exactly when the result is inexact and `sign_i` is 1.
- R8: `rounded_up_o` is 1 exactly when the increment is applied.
- R9: `carry_o` is 1 exactly when an increment is applied to a truncated mantissa of all ones. In that case `mant_o` is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mant_i | input | MANT_W | Normalized mantissa with guard (bit 1) and round (bit 0) appended |
| sticky_i | input | 1 | OR of all bits shifted out below the round bit |
| sign_i | input | 1 | Sign of the value, 1 = negative |
| mode_i | input | 2 | Rounding mode: 0 nearest, 1 toward zero, 2 toward +inf, 3 toward -inf |
| mant_o | output | MANT_W-2 | Rounded mantissa without guard and round bits |
| inexact_o | output | 1 | Precision was lost |
| rounded_up_o | output | 1 | One was added to the truncated mantissa |
| carry_o | output | 1 | Carry out of the mantissa top after increment |

## Verification
The stage holds no state, so a wrong decision shows at the outputs in the same evaluation. A mode decoded wrongly shows at once as an off-by-one `mant_o` together with a wrong `rounded_up_o`. A broken carry chain shows only for inputs whose low truncated bits are ones. For that reason the stimulus forces long runs of ones near the top and bottom of the mantissa, and includes exact ties.

// File: rtl/grs_pkg.sv
package grs_pkg;
  typedef enum logic [1:0] {
    RM_NEAREST = 2'd0,
    RM_ZERO    = 2'd1,
    RM_POS     = 2'd2,
    RM_NEG     = 2'd3
  } rmode_e;

  // increment decision from the discarded bits, the kept LSB, sign and mode
  function automatic logic want_increment(input logic g, input logic r,
                                          input logic s, input logic lsb,
                                          input logic neg, input rmode_e m);
    logic lost;
    lost = g | r | s;
    case (m)
      RM_NEAREST: want_increment = g & (r | s | lsb);
      RM_ZERO:    want_increment = 1'b0;
      RM_POS:     want_increment = lost & ~neg;
      default:    want_increment = lost & neg;
    endcase
  endfunction
endpackage

// File: rtl/grs_decide.sv
module grs_decide
  import grs_pkg::*;
(
  input  logic   guard_i,
  input  logic   round_i,
  input  logic   sticky_i,
  input  logic   lsb_i,
  input  logic   sign_i,
  input  rmode_e mode_i,
  output logic   lost_o,
  output logic   inc_o
);
  assign lost_o = guard_i | round_i | sticky_i;
  assign inc_o  = want_increment(guard_i, round_i, sticky_i, lsb_i, sign_i, mode_i);

  always_comb begin
    assert_exact_no_inc_R2: assert (lost_o || !inc_o);
    assert_rz_never_R5:     assert (!(mode_i == RM_ZERO && inc_o));
    assert_pos_sign_R6:     assert (!(mode_i == RM_POS && inc_o && sign_i));
    assert_neg_sign_R7:     assert (!(mode_i == RM_NEG && inc_o && !sign_i));
    assert_rn_guard_R4:     assert (!(mode_i == RM_NEAREST && inc_o && !guard_i));
  end
endmodule

// File: rtl/grs_incr.sv
module grs_incr #(
  parameter int unsigned W = 24
) (
  input  logic [W-1:0] val_i,
  input  logic         inc_i,
  output logic [W-1:0] sum_o,
  output logic         cout_o
);
  logic [W:0] chain;
  assign chain[0] = inc_i;

  for (genvar b = 0; b < W; b++) begin : g_bit
    assign sum_o[b]     = val_i[b] ^ chain[b];
    assign chain[b+1]   = val_i[b] & chain[b];
  end

  assign cout_o = chain[W];

  always_comb begin
    assert_carry_wraps_R9: assert (!cout_o || (sum_o == '0 && inc_i));
    assert_hold_no_inc_R1: assert (inc_i || (sum_o == val_i && !cout_o));
  end
endmodule

// File: rtl/grs_round_unit.sv
module grs_round_unit
  import grs_pkg::*;
#(
  parameter int unsigned MANT_W = 26
) (
  input  logic [MANT_W-1:0] mant_i,
  input  logic              sticky_i,
  input  logic              sign_i,
  input  logic [1:0]        mode_i,
  output logic [MANT_W-3:0] mant_o,
  output logic              inexact_o,
  output logic              rounded_up_o,
  output logic              carry_o
);
  localparam int unsigned KEEP_W = MANT_W - 2;

  logic [KEEP_W-1:0] kept;
  logic              guard_bit, round_bit;
  logic              lost_evt, inc_evt;

  assign kept      = mant_i[MANT_W-1:2];
  assign guard_bit = mant_i[1];
  assign round_bit = mant_i[0];

  grs_decide u_decide (
    .guard_i  (guard_bit),
    .round_i  (round_bit),
    .sticky_i (sticky_i),
    .lsb_i    (kept[0]),
    .sign_i   (sign_i),
    .mode_i   (rmode_e'(mode_i)),
    .lost_o   (lost_evt),
    .inc_o    (inc_evt)
  );

  grs_incr #(.W(KEEP_W)) u_incr (
    .val_i  (kept),
    .inc_i  (inc_evt),
    .sum_o  (mant_o),
    .cout_o (carry_o)
  );

  assign inexact_o    = lost_evt;
  assign rounded_up_o = inc_evt;

  always_comb begin
    assert_inexact_flag_R3: assert (inexact_o == (mant_i[1:0] != 2'b00 || sticky_i));
    assert_upflag_carry_R8: assert (!carry_o || rounded_up_o);
  end
endmodule

// File: tb/grs_round_unit_tb.sv
module grs_round_unit_tb_top;
  localparam int unsigned MANT_W     = 26;
  localparam int unsigned KEEP_W     = MANT_W - 2;
  localparam time         CLK_PERIOD = 10ns;

  logic              clk = 1'b0;
  logic [MANT_W-1:0] mant_i;
  logic              sticky_i, sign_i;
  logic [1:0]        mode_i;
  logic [KEEP_W-1:0] mant_o;
  logic              inexact_o, rounded_up_o, carry_o;
  int                n_chk = 0, n_fail = 0;
  bit                finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  grs_round_unit #(.MANT_W(MANT_W)) dut_i (
    .mant_i(mant_i), .sticky_i(sticky_i), .sign_i(sign_i), .mode_i(mode_i),
    .mant_o(mant_o), .inexact_o(inexact_o), .rounded_up_o(rounded_up_o),
    .carry_o(carry_o)
  );

  // reference: round-half decision written from the value's perspective
  function automatic bit ref_up(input logic [MANT_W-1:0] m, input bit s,
                                input bit neg, input logic [1:0] md);
    bit above_half, at_half, any;
    above_half = m[1] && (m[0] || s);
    at_half    = m[1] && !m[0] && !s;
    any        = (m[1:0] != 0) || s;
    if (md == 2'd0) return above_half || (at_half && m[2]);
    if (md == 2'd1) return 1'b0;
    if (md == 2'd2) return any && !neg;
    return any && neg;
  endfunction

  task automatic check(input string req, input string what,
                       input logic [KEEP_W+2:0] act, input logic [KEEP_W+2:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h (mant=%0h st=%0b sg=%0b md=%0d)",
               req, what, act, exp, mant_i, sticky_i, sign_i, mode_i);
    end
  endtask

  task automatic apply(input logic [MANT_W-1:0] m, input bit s, input bit neg,
                       input logic [1:0] md, input string req);
    bit up, lost;
    logic [KEEP_W:0] sum;
    @(negedge clk);
    mant_i = m; sticky_i = s; sign_i = neg; mode_i = md;
    up   = ref_up(m, s, neg, md);
    lost = (m[1:0] != 0) || s;
    sum  = {1'b0, m[MANT_W-1:2]} + (KEEP_W+1)'(up);
    @(posedge clk); #1;
    check(req, "mant", {3'b0, mant_o}, {3'b0, sum[KEEP_W-1:0]});
    check(req, "flags", {{KEEP_W{1'b0}}, inexact_o, rounded_up_o, carry_o},
          {{KEEP_W{1'b0}}, lost, up, sum[KEEP_W]});
  endtask

  initial begin
    mant_i = '0; sticky_i = 0; sign_i = 0; mode_i = 0;
    void'($urandom(32'd4711));
    @(posedge clk); #1;
    // R2 idle state with zero inputs
    check("R2", "idle", {{KEEP_W{1'b0}}, inexact_o, rounded_up_o, carry_o}, '0);
    for (int md = 0; md < 4; md++) begin
      apply({{KEEP_W{1'b1}}, 2'b00}, 0, md[0], md[1:0], "R2");          // exact, all ones
      apply({{(KEEP_W-1){1'b0}}, 1'b1, 2'b11}, 1, 0, md[1:0], "R6");     // R6 R7 R5 sign+
      apply({{(KEEP_W-1){1'b0}}, 1'b1, 2'b11}, 1, 1, md[1:0], "R7");
      apply({{KEEP_W{1'b1}}, 2'b10}, 0, 0, md[1:0], "R9");             // carry to 2.0
      apply({{KEEP_W{1'b1}}, 2'b01}, 0, 1, md[1:0], "R5");
    end
    // R4 ties: even stays, odd goes up; guard with sticky goes up
    apply({{(KEEP_W-1){1'b0}}, 1'b0, 2'b10}, 0, 0, 2'd0, "R4");
    apply({{(KEEP_W-1){1'b0}}, 1'b1, 2'b10}, 0, 0, 2'd0, "R4");
    apply({{(KEEP_W-1){1'b0}}, 1'b0, 2'b10}, 1, 0, 2'd0, "R4");
    apply({{(KEEP_W-1){1'b0}}, 1'b1, 2'b01}, 1, 1, 2'd0, "R4");
    // R3 sticky alone makes it inexact
    apply({{KEEP_W{1'b0}}, 2'b00}, 1, 0, 2'd1, "R3");
    for (int i = 0; i < 3000; i++) begin
      logic [MANT_W-1:0] m;
      m = MANT_W'({$urandom, $urandom});
      if (i % 5 == 0) m[MANT_W-1:2] = {KEEP_W{1'b1}};
      if (i % 7 == 0) m[1:0] = 2'b10;
      apply(m, 1'($urandom), 1'($urandom), 2'($urandom), "R1_R8");
    end
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule